// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit turns a decoded instruction into the effective address and the operand for an accumulator load. It takes a 4-bit mode code, an address field and a register select. Alongside them come the current instruction address, the program counter already advanced past the whole instruction, the accumulator, the selected general register, an index register and a base register. It walks through zero, one or two reads on a synchronous memory port, depending on the mode. It also returns the pointer update for the auto-modifying modes.

A pulse on `start_i` with the instruction fields present begins a fetch. All inputs are captured in that cycle. The memory port is a one-cycle request, and the data comes back with `mem_valid_i` one cycle later. When the fetch ends, `done_o` is high for exactly one cycle. In that same cycle `ea_o` and `operand_o` hold the result, and any register write-back is presented. The caller keeps `start_i` low until `done_o` has been seen.

Top module: `opf_unit`

## Requirements
- R1: Mode codes 11 to 15 are illegal. They give `done_o` together with `illegal_o` one cycle after start, issue no memory request and do no register write.
- R2: Implied mode (code 0) returns `acc_i` as the operand, issues no memory request and finishes one cycle after start.
- R3: Immediate mode (code 1) returns the address field, zero-extended, as the operand. It reports `inst_addr_i + 1` as the effective address, issues no memory request and finishes one cycle after start.
- R4: Direct mode (code 2) makes one read at the address field and returns the read word as the operand. The effective address is the field, and `done_o` rises three cycles after start. Codes 2 and 3 differ only in bit 0, which selects indirection.
- R5: Indirect mode (code 3) makes two reads, the first at the field and the second at the word that the first returns. That word is the effective address, the second word is the operand, and `done_o` rises five cycles after start.
- R6: Relative mode (code 4) uses `pc_next_i + field` as the effective address and makes one read there.
- R7: Index mode (code 5) uses `index_i + field`, and base mode (code 6) uses `base_i + field`, each with one read.
- R8: Register mode (code 7) returns the selected register with no memory access. Register-indirect mode (code 8) reads at the register's value.
- R9: Auto-increment mode (code 9) reads at the register value. In the `done_o` cycle it writes that value plus one back to the selected register. A register write occurs only in a `done_o` cycle.
- R10: Auto-decrement mode (code 10) subtracts one from the register first, reads at the result and writes the result back in the `done_o` cycle.
- R11: `done_o` lasts exactly one cycle, and each memory request lasts exactly one cycle.
- R12: All address sums and pointer updates wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch |
| mode_i | input | 4 | Addressing mode code |
| field_i | input | AW | Address field / second instruction word |
| rsel_i | input | RW | General register select |
| inst_addr_i | input | AW | Address of the instruction |
| pc_next_i | input | AW | PC past the whole instruction |
| acc_i | input | DW | Accumulator value |
| reg_rdata_i | input | DW | Contents of the selected register |
| index_i | input | AW | Index register |
| base_i | input | AW | Base register |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| ea_o | output | AW | Effective address |
| operand_o | output | DW | Operand |
| done_o | output | 1 | Fetch complete, one cycle |
| illegal_o | output | 1 | Illegal mode, with done |
| reg_we_o | output | 1 | Register write-back enable |
| reg_waddr_o | output | RW | Register write-back select |
| reg_wdata_o | output | DW | Register write-back value |

## Verification
The assertions assume that `start_i` is pulsed only while the unit is idle, that is, never between a start and its `done_o`. They also assume that the memory returns `mem_valid_i` exactly one cycle after each request. The checker's copies of the mode, select and register value are valid only under that rule. The bench keeps to it by having every scenario task pulse `start_i` for one cycle and then wait for `done_o`. Its memory model answers each request on the following edge and never raises valid on its own.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam logic [3:0] MODE_IMPL = 4'd0;
  localparam logic [3:0] MODE_IMM  = 4'd1;
  localparam logic [3:0] MODE_DIR  = 4'd2;
  localparam logic [3:0] MODE_IND  = 4'd3;
  localparam logic [3:0] MODE_REL  = 4'd4;
  localparam logic [3:0] MODE_IDX  = 4'd5;
  localparam logic [3:0] MODE_BASE = 4'd6;
  localparam logic [3:0] MODE_REG  = 4'd7;
  localparam logic [3:0] MODE_RIND = 4'd8;
  localparam logic [3:0] MODE_AINC = 4'd9;
  localparam logic [3:0] MODE_ADEC = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ1, ST_WAIT1, ST_REQ2, ST_WAIT2, ST_FIN
  } opf_state_e;
endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] field_i,
  input  logic [AW-1:0] inst_addr_i,
  input  logic [AW-1:0] pc_next_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] ea_o,
  output logic [DW-1:0] op_o,
  output logic [1:0]    nreads_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_val_o,
  output logic          illegal_o
);
  localparam logic [AW-1:0] AONE = AW'(1);
  localparam logic [DW-1:0] DONE = DW'(1);

  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_dec;

  assign reg_addr = reg_val_i[AW-1:0];
  assign reg_dec  = reg_val_i - DONE;

  always_comb begin
    ea_o      = '0;
    op_o      = '0;
    nreads_o  = 2'd0;
    wb_en_o   = 1'b0;
    wb_val_o  = reg_val_i;
    illegal_o = 1'b0;
    case (mode_i)
      MODE_IMPL: op_o = acc_i;
      MODE_IMM: begin
        ea_o = inst_addr_i + AONE;
        op_o = DW'(field_i);
      end
      MODE_DIR: begin
        ea_o = field_i;
        nreads_o = 2'd1;
      end
      MODE_IND: begin
        ea_o = field_i;            // pointer location; replaced after first read
        nreads_o = 2'd2;
      end
      MODE_REL: begin
        ea_o = pc_next_i + field_i;
        nreads_o = 2'd1;
      end
      MODE_IDX: begin
        ea_o = index_i + field_i;
        nreads_o = 2'd1;
      end
      MODE_BASE: begin
        ea_o = base_i + field_i;
        nreads_o = 2'd1;
      end
      MODE_REG: op_o = reg_val_i;
      MODE_RIND: begin
        ea_o = reg_addr;
        nreads_o = 2'd1;
      end
      MODE_AINC: begin
        ea_o = reg_addr;
        nreads_o = 2'd1;
        wb_en_o = 1'b1;
        wb_val_o = reg_val_i + DONE;
      end
      MODE_ADEC: begin
        ea_o = reg_dec[AW-1:0];
        nreads_o = 2'd1;
        wb_en_o = 1'b1;
        wb_val_o = reg_dec;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] rsel_i,
  input  logic [AW-1:0] ea_i,
  input  logic [DW-1:0] op_i,
  input  logic [1:0]    nreads_i,
  input  logic          wb_en_i,
  input  logic [DW-1:0] wb_val_i,
  input  logic          illegal_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] ea_o,
  output logic [DW-1:0] operand_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic          reg_we_o,
  output logic [RW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o
);
  opf_state_e    state_q;
  logic [AW-1:0] ea_q;
  logic [DW-1:0] op_q;
  logic          two_q, wb_en_q, ill_q;
  logic [DW-1:0] wb_val_q;
  logic [RW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ea_q     <= '0;
      op_q     <= '0;
      two_q    <= 1'b0;
      wb_en_q  <= 1'b0;
      wb_val_q <= '0;
      ill_q    <= 1'b0;
      sel_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          ea_q     <= ea_i;
          op_q     <= op_i;
          two_q    <= (nreads_i == 2'd2);
          wb_en_q  <= wb_en_i;
          wb_val_q <= wb_val_i;
          ill_q    <= illegal_i;
          sel_q    <= rsel_i;
          state_q  <= (nreads_i == 2'd0) ? ST_FIN : ST_REQ1;
        end
        ST_REQ1: state_q <= ST_WAIT1;
        ST_WAIT1: if (mem_valid_i) begin
          if (two_q) begin
            ea_q    <= mem_rdata_i[AW-1:0];
            state_q <= ST_REQ2;
          end else begin
            op_q    <= mem_rdata_i;
            state_q <= ST_FIN;
          end
        end
        ST_REQ2: state_q <= ST_WAIT2;
        ST_WAIT2: if (mem_valid_i) begin
          op_q    <= mem_rdata_i;
          state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_REQ1) || (state_q == ST_REQ2);
  assign mem_addr_o  = ea_q;
  assign ea_o        = ea_q;
  assign operand_o   = op_q;
  assign done_o      = (state_q == ST_FIN);
  assign illegal_o   = done_o && ill_q;
  assign reg_we_o    = done_o && wb_en_q;
  assign reg_waddr_o = sel_q;
  assign reg_wdata_o = wb_val_q;
endmodule

// File: rtl/opf_unit.sv
module opf_unit #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [AW-1:0] field_i,
  input  logic [RW-1:0] rsel_i,
  input  logic [AW-1:0] inst_addr_i,
  input  logic [AW-1:0] pc_next_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic [AW-1:0] index_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] ea_o,
  output logic [DW-1:0] operand_o,
  output logic          done_o,
  output logic          illegal_o,
  output logic          reg_we_o,
  output logic [RW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o
);
  logic [AW-1:0] calc_ea;
  logic [DW-1:0] calc_op, calc_wb;
  logic [1:0]    calc_nrd;
  logic          calc_wben, calc_ill;

  opf_ea_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode_i(mode_i), .field_i(field_i), .inst_addr_i(inst_addr_i),
    .pc_next_i(pc_next_i), .acc_i(acc_i), .reg_val_i(reg_rdata_i),
    .index_i(index_i), .base_i(base_i), .ea_o(calc_ea), .op_o(calc_op),
    .nreads_o(calc_nrd), .wb_en_o(calc_wben), .wb_val_o(calc_wb),
    .illegal_o(calc_ill)
  );

  opf_ctrl #(.AW(AW), .DW(DW), .RW(RW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rsel_i(rsel_i),
    .ea_i(calc_ea), .op_i(calc_op), .nreads_i(calc_nrd), .wb_en_i(calc_wben),
    .wb_val_i(calc_wb), .illegal_i(calc_ill), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i),
    .ea_o(ea_o), .operand_o(operand_o), .done_o(done_o), .illegal_o(illegal_o),
    .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o)
  );
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] field_i,
  input logic [RW-1:0] rsel_i,
  input logic [DW-1:0] reg_rdata_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic          illegal_o,
  input logic          reg_we_o,
  input logic [RW-1:0] reg_waddr_o,
  input logic [DW-1:0] reg_wdata_o
);
  logic [3:0]    cap_mode;
  logic [RW-1:0] cap_sel;
  logic [DW-1:0] cap_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_mode <= '0;
      cap_sel  <= '0;
      cap_reg  <= '0;
    end else if (start_i) begin
      cap_mode <= mode_i;
      cap_sel  <= rsel_i;
      cap_reg  <= reg_rdata_i;
    end
  end

  AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i >= 4'd11 |=> done_o && illegal_o && !mem_req_o && !reg_we_o); // R1
  AST_NOMEM_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (mode_i == 4'd0 || mode_i == 4'd1 || mode_i == 4'd7)
    |=> done_o && !mem_req_o && !illegal_o); // R2
  AST_DIRECT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 4'd2 |=> mem_req_o && mem_addr_o == $past(field_i)); // R4
  AST_INDIRECT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 4'd3 |=> mem_req_o && mem_addr_o == $past(field_i)); // R5
  AST_RIND_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i == 4'd8 |=> mem_req_o && mem_addr_o == $past(reg_rdata_i[AW-1:0])); // R8
  AST_WB_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> done_o && reg_waddr_o == cap_sel); // R9
  AST_AINC_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && cap_mode == 4'd9 |-> reg_wdata_o == cap_reg + DW'(1)); // R9
  AST_ADEC_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o && cap_mode == 4'd10 |-> reg_wdata_o == cap_reg - DW'(1)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R11
endmodule

bind opf_unit opf_checker #(.AW(AW), .DW(DW), .RW(RW)) u_opf_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
  .field_i(field_i), .rsel_i(rsel_i), .reg_rdata_i(reg_rdata_i),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .done_o(done_o),
  .illegal_o(illegal_o), .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o),
  .reg_wdata_o(reg_wdata_o)
);

// File: tb/opf_unit_test.sv
`timescale 1ns/1ps
module opf_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] field = '0;
  logic [2:0]  rsel = '0;
  logic [15:0] inst_addr = '0, pc_next = '0, acc = '0, index_r = '0, base_r = '0;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_valid = 1'b0;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic [15:0] ea, operand, reg_wdata;
  logic        done, illegal, reg_we;
  logic [2:0]  reg_waddr;

  logic [15:0] mem [256];
  logic [15:0] rf [8];
  int req_cnt = 0;
  logic [15:0] prev_addr = '0, last_addr = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  opf_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .field_i(field),
    .rsel_i(rsel), .inst_addr_i(inst_addr), .pc_next_i(pc_next), .acc_i(acc),
    .reg_rdata_i(reg_rdata), .index_i(index_r), .base_i(base_r),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_rdata_i(mem_rdata), .ea_o(ea), .operand_o(operand), .done_o(done),
    .illegal_o(illegal), .reg_we_o(reg_we), .reg_waddr_o(reg_waddr),
    .reg_wdata_o(reg_wdata)
  );

  assign reg_rdata = rf[rsel];

  always @(posedge clk) begin
    mem_valid <= mem_req;
    if (mem_req) begin
      mem_rdata <= mem[mem_addr[7:0]];
      req_cnt   <= req_cnt + 1;
      prev_addr <= last_addr;
      last_addr <= mem_addr;
    end
    if (reg_we) rf[reg_waddr] <= reg_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [15:0] f, input logic [2:0] s,
                        output int cyc, output int nreq);
    int r0;
    @(negedge clk);
    mode = m; field = f; rsel = s; start = 1'b1;
    r0 = req_cnt;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    nreq = req_cnt - r0;
    chk(done, "done seen", 32'(done), 1);
  endtask

  task automatic t_reset();
    chk(!done && !mem_req && !reg_we && !illegal, "R11 reset idle",
        {28'd0, done, mem_req, reg_we, illegal}, 0);
  endtask

  task automatic t_implied();
    int c, n;
    acc = 16'h1234;
    run_op(4'd0, 16'd50, 3'd1, c, n);
    chk(operand == 16'h1234, "R2 implied operand", operand, 16'h1234);
    chk(c == 1 && n == 0, "R2 implied timing/no access", c * 10 + n, 10);
  endtask

  task automatic t_immediate();
    int c, n;
    run_op(4'd1, 16'd50, 3'd1, c, n);
    chk(operand == 16'd50, "R3 immediate operand", operand, 50);
    chk(ea == 16'd21, "R3 immediate ea", ea, 21);
    chk(c == 1 && n == 0, "R3 immediate timing/no access", c * 10 + n, 10);
  endtask

  task automatic t_direct();
    int c, n;
    run_op(4'd2, 16'd50, 3'd1, c, n);
    chk(operand == 16'd80, "R4 direct operand", operand, 80);
    chk(ea == 16'd50 && last_addr == 16'd50, "R4 direct ea", ea, 50);
    chk(c == 3 && n == 1, "R4 direct timing/reads", c * 10 + n, 31);
  endtask

  task automatic t_indirect();
    int c, n;
    run_op(4'd3, 16'd50, 3'd1, c, n);
    chk(operand == 16'd30, "R5 indirect operand", operand, 30);
    chk(ea == 16'd80, "R5 indirect ea", ea, 80);
    chk(prev_addr == 16'd50 && last_addr == 16'd80, "R5 read order", {prev_addr, last_addr}, {16'd50, 16'd80});
    chk(c == 5 && n == 2, "R5 indirect timing/reads", c * 10 + n, 52);
  endtask

  task automatic t_relative();
    int c, n;
    run_op(4'd4, 16'd50, 3'd1, c, n);
    chk(ea == 16'd72 && operand == 16'd35, "R6 relative", {ea, operand}, {16'd72, 16'd35});
  endtask

  task automatic t_index_base();
    int c, n;
    run_op(4'd5, 16'd50, 3'd1, c, n);
    chk(ea == 16'd60 && operand == 16'd90, "R7 index", {ea, operand}, {16'd60, 16'd90});
    run_op(4'd6, 16'd50, 3'd1, c, n);
    chk(ea == 16'd150 && operand == 16'h0196, "R7 base", {ea, operand}, {16'd150, 16'h0196});
  endtask

  task automatic t_register();
    int c, n;
    run_op(4'd7, 16'd50, 3'd1, c, n);
    chk(operand == 16'd40 && n == 0 && c == 1, "R8 register", operand, 40);
    run_op(4'd8, 16'd50, 3'd1, c, n);
    chk(ea == 16'd40 && operand == 16'd70 && n == 1, "R8 register-indirect", {ea, operand}, {16'd40, 16'd70});
  endtask

  task automatic t_auto();
    int c, n;
    run_op(4'd9, 16'd50, 3'd1, c, n);
    chk(ea == 16'd40 && operand == 16'd70, "R9 autoinc access", {ea, operand}, {16'd40, 16'd70});
    chk(reg_we && reg_waddr == 3'd1 && reg_wdata == 16'd41, "R9 autoinc writeback", reg_wdata, 41);
    @(negedge clk);
    chk(rf[1] == 16'd41 && !reg_we, "R9 register after", rf[1], 41);
    rf[1] = 16'd40;
    run_op(4'd10, 16'd50, 3'd1, c, n);
    chk(ea == 16'd39 && operand == 16'd45, "R10 autodec access", {ea, operand}, {16'd39, 16'd45});
    chk(reg_we && reg_wdata == 16'd39, "R10 autodec writeback", reg_wdata, 39);
    @(negedge clk);
    chk(rf[1] == 16'd39, "R10 register after", rf[1], 39);
  endtask

  task automatic t_wrap();
    int c, n;
    pc_next = 16'hFFF0;
    run_op(4'd4, 16'h0020, 3'd1, c, n);
    chk(ea == 16'h0010 && operand == 16'h0110, "R12 relative wrap", {ea, operand}, {16'h0010, 16'h0110});
    pc_next = 16'd22;
    rf[2] = 16'd0;
    run_op(4'd10, 16'd0, 3'd2, c, n);
    chk(ea == 16'hFFFF && operand == 16'h01FF && reg_wdata == 16'hFFFF, "R12 autodec wrap",
        {ea, reg_wdata}, {16'hFFFF, 16'hFFFF});
  endtask

  task automatic t_illegal();
    int c, n;
    run_op(4'd12, 16'd50, 3'd1, c, n);
    chk(illegal && !reg_we && c == 1 && n == 0, "R1 illegal 12", c * 10 + n, 10);
    run_op(4'd15, 16'd50, 3'd1, c, n);
    chk(illegal && c == 1 && n == 0, "R1 illegal 15", c * 10 + n, 10);
    run_op(4'd2, 16'd50, 3'd1, c, n);
    chk(!illegal, "R1 legal clears flag", 32'(illegal), 0);
  endtask

  task automatic t_pulse();
    @(negedge clk);
    chk(!done && !mem_req, "R11 single-cycle done", {30'd0, done, mem_req}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i) + 16'h0100;
    mem[50] = 16'd80; mem[80] = 16'd30; mem[72] = 16'd35; mem[60] = 16'd90;
    mem[40] = 16'd70; mem[39] = 16'd45;
    for (int i = 0; i < 8; i++) rf[i] = 16'(i * 3);
    rf[1] = 16'd40;
    inst_addr = 16'd20; pc_next = 16'd22; index_r = 16'd10; base_r = 16'd100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_implied();
    t_pulse();
    t_immediate();
    t_direct();
    t_pulse();
    t_indirect();
    t_relative();
    t_index_base();
    t_register();
    t_auto();
    t_wrap();
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule